// File: doc/BRIEF.md
# Dual-Segment Playback Swap Controller

This block chooses which of two pattern segments (S0 or S1) is playing and which sample index of that segment is presented. It does not hold pattern data. It only produces the segment select, the sample index and a stop flag. A shared free-running time count is applied to the block. Each segment turns that count into a lap number and an in-lap index through its own divider and cycle length.

Software issues a configuration write that names a target segment and gives four more values: a repeat count, a divider, a cycle length and a transition mode. There are two kinds of playback:

- **Endless playback** begins at once. It is selected by a write to the segment already playing, or by a write carrying the all-ones repeat value. In alternating mode it swaps between the two segments on lap parity.
- **Finite playback** is armed by any other write. It waits for a start condition: a lap boundary, an absolute time, or the level on one of four pins. It then plays the segment for a set number of laps and freezes on that segment's last sample.

Top module: `seg_swap_ctrl`

## Requirements
- R1: After reset the block waits with S0 selected (seg_o = 0), stop_o low and idx_o = 0. Each segment starts with divider 10 and cycle length 1.
- R2: A write naming the segment already selected enters endless playback on that segment. It clears stop_o, zeroes that segment's index offset, and the index then follows the time count.
- R3: A write naming the other segment with repeat value 0xFFFF switches seg_o to that segment in the next cycle, clears stop_o and enters endless playback with offset 0.
- R4: Any other write stores the repeat count and the target and enters the waiting state; seg_o does not change. While waiting, mode 0 (immediate) and mode 4 (alternate) never start playback.
- R5: Mode 1 (lap sync) starts once the target segment's lap at the current time exceeds its lap at the time of the write. The start uses offset 0.
- R6: Mode 2 (time) starts once the time count is at or past the written target time. The offset becomes the target segment's index at that moment.
- R7: Mode 3 (pin) starts while the pin chosen by cfg_pin_i is high, after a two-flop synchronizer. The other pins are ignored. The offset becomes the index at that moment.
- R8: A start clears stop_o, records the start lap and selects the target segment. In finite playback stop_o rises when the lap exceeds start+repeat+1, or when the lap exceeds start+repeat and the index is at or above the offset. It stays set until a write, and while it is set idx_o is the cycle length minus 1.
- R9: The tick count is time/divider. lap = tick / cycle and index = tick mod cycle. A divider or cycle of 0 counts as 1. When not stopped, idx_o = (index + cycle − offset) mod cycle for the selected segment.
- R10: In endless playback under mode 4, the block records the target segment's lap at the time of the write. The selection then toggles each time the lap passes the recorded one with opposite parity, and the new lap is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_i | input | TIME_W | Free-running time count |
| pin_i | input | PIN_N | Asynchronous trigger pins |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_seg_i | input | 1 | Target segment (0 = S0, 1 = S1) |
| cfg_rep_i | input | REP_W | Repeat count; all ones means endless |
| cfg_div_i | input | DIV_W | Divider for the target segment |
| cfg_cyc_i | input | CYC_W | Cycle length for the target segment |
| cfg_mode_i | input | 3 | Transition mode 0..4 |
| cfg_pin_i | input | PIN_W | Pin selected for mode 3 |
| cfg_target_i | input | TIME_W | Start time for mode 2 |
| seg_o | output | 1 | Selected segment |
| idx_o | output | CYC_W | Presented sample index |
| stop_o | output | 1 | Finite playback finished |

## Verification
The bench drives each start mode from a parked state and checks both sides of each condition:

- **Lap sync:** the last time before the lap boundary and the first time on it.
- **Time mode:** the time just below the target and exactly at it.
- **Pin mode:** a high level on a pin that is not selected, then on the one that is.

These cases separate an early start from a late one, and an offset of zero from an offset taken at the start moment.

The stop boundary is approached from the index just below the offset and at the offset, which shows whether the second stop rule compares with the right sense. Alternation is checked across lap parity changes, and degenerate divider and cycle values of 0 are included. Random writes, pin changes and time steps then mix all modes, including repeated writes while stopped or waiting.

// File: rtl/seg_swap_pkg.sv
package seg_swap_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_FIN  = 2'd1,
        ST_INF  = 2'd2
    } swap_state_e;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_NOW  = 3'd0;
    localparam logic [MODE_W-1:0] MODE_LAP  = 3'd1;
    localparam logic [MODE_W-1:0] MODE_TIME = 3'd2;
    localparam logic [MODE_W-1:0] MODE_PIN  = 3'd3;
    localparam logic [MODE_W-1:0] MODE_ALT  = 3'd4;

    localparam int SEG_N = 2;

endpackage

// File: rtl/seg_swap_timebase.sv
module seg_swap_timebase #(
    parameter int TIME_W = 20,
    parameter int DIV_W  = 8,
    parameter int CYC_W  = 8
) (
    input  logic [TIME_W-1:0] time_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [CYC_W-1:0]  cyc_i,
    output logic [TIME_W-1:0] lap_o,
    output logic [CYC_W-1:0]  idx_o
);
    logic [TIME_W-1:0] div_e;
    logic [TIME_W-1:0] cyc_e;
    logic [TIME_W-1:0] tick;
    logic [TIME_W-1:0] rem;

    // zero divider or cycle behaves as one (R9)
    always_comb begin
        div_e = (div_i == '0) ? TIME_W'(1) : TIME_W'(div_i);
        cyc_e = (cyc_i == '0) ? TIME_W'(1) : TIME_W'(cyc_i);
        tick  = time_i / div_e;
        lap_o = tick / cyc_e;
        rem   = tick % cyc_e;
        idx_o = rem[CYC_W-1:0];
    end
endmodule

// File: rtl/seg_swap_pin_sync.sv
module seg_swap_pin_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/seg_swap_index_map.sv
module seg_swap_index_map #(
    parameter int CYC_W = 8
) (
    input  logic [CYC_W-1:0] idx_i,
    input  logic [CYC_W-1:0] cyc_i,
    input  logic [CYC_W-1:0] off_i,
    input  logic             stop_i,
    output logic [CYC_W-1:0] idx_o
);
    localparam int W = CYC_W + 1;

    logic [W-1:0] c;
    logic [W-1:0] i_red;
    logic [W-1:0] o_red;
    logic [W-1:0] s;

    always_comb begin
        c     = (cyc_i == '0) ? W'(1) : W'(cyc_i);
        i_red = W'(idx_i) % c;
        o_red = W'(off_i) % c;
        s     = (i_red + c - o_red) % c;
        idx_o = stop_i ? CYC_W'(c - W'(1)) : CYC_W'(s);
    end
endmodule

// File: rtl/seg_swap_ctrl.sv
module seg_swap_ctrl
    import seg_swap_pkg::*;
#(
    parameter int TIME_W = 20,
    parameter int DIV_W  = 8,
    parameter int CYC_W  = 8,
    parameter int REP_W  = 16,
    parameter int PIN_N  = 4,
    parameter int PIN_W  = $clog2(PIN_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_i,
    input  logic [PIN_N-1:0]  pin_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_seg_i,
    input  logic [REP_W-1:0]  cfg_rep_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic [CYC_W-1:0]  cfg_cyc_i,
    input  logic [2:0]        cfg_mode_i,
    input  logic [PIN_W-1:0]  cfg_pin_i,
    input  logic [TIME_W-1:0] cfg_target_i,
    output logic              seg_o,
    output logic [CYC_W-1:0]  idx_o,
    output logic              stop_o
);
    localparam int SUM_W = ((TIME_W > REP_W) ? TIME_W : REP_W) + 2;
    localparam logic [REP_W-1:0] REP_FOREVER = '1;

    typedef struct packed {
        swap_state_e                      st;
        logic                             cur;
        logic                             req;
        logic                             stop;
        logic                             ext;
        logic                             ext_sync;
        logic [REP_W-1:0]                 rep;
        logic [MODE_W-1:0]                mode;
        logic [PIN_W-1:0]                 pin;
        logic [TIME_W-1:0]                target;
        logic [TIME_W-1:0]                wr_time;
        logic [TIME_W-1:0]                ext_last;
        logic [SEG_N-1:0][DIV_W-1:0]      div;
        logic [SEG_N-1:0][CYC_W-1:0]      cyc;
        logic [SEG_N-1:0][TIME_W-1:0]     start;
        logic [SEG_N-1:0][CYC_W-1:0]      off;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [TIME_W-1:0] lap_s [SEG_N];
    logic [CYC_W-1:0]  idx_s [SEG_N];
    logic [PIN_N-1:0]  pin_sync;
    logic [TIME_W-1:0] ref_div, ref_cyc, ref_lap;
    logic [TIME_W-1:0] lap_r;
    logic [CYC_W-1:0]  idx_r;
    logic              fire;
    logic [SUM_W-1:0]  base, lap_x;
    logic [CYC_W-1:0]  map_idx, map_cyc, map_off, idx_d, idx_q;

    // per-segment lap and index of the present time
    for (genvar g = 0; g < SEG_N; g++) begin : g_tb
        seg_swap_timebase #(
            .TIME_W(TIME_W),
            .DIV_W (DIV_W),
            .CYC_W (CYC_W)
        ) tb_i (
            .time_i(time_i),
            .div_i (ctrl_q.div[g]),
            .cyc_i (ctrl_q.cyc[g]),
            .lap_o (lap_s[g]),
            .idx_o (idx_s[g])
        );
    end

    seg_swap_pin_sync #(.WIDTH(PIN_N)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pin_i),
        .q_o  (pin_sync)
    );

    // lap of the target segment at the moment of the last write
    always_comb begin
        ref_div = (ctrl_q.div[ctrl_q.req] == '0) ? TIME_W'(1) : TIME_W'(ctrl_q.div[ctrl_q.req]);
        ref_cyc = (ctrl_q.cyc[ctrl_q.req] == '0) ? TIME_W'(1) : TIME_W'(ctrl_q.cyc[ctrl_q.req]);
        ref_lap = (ctrl_q.wr_time / ref_div) / ref_cyc;
    end

    always_comb begin
        ctrl_d = ctrl_q;
        lap_r  = lap_s[ctrl_q.req];
        idx_r  = idx_s[ctrl_q.req];

        case (ctrl_q.mode)
            MODE_LAP:  fire = (lap_r > ref_lap);
            MODE_TIME: fire = (ctrl_q.target <= time_i);
            MODE_PIN:  fire = pin_sync[ctrl_q.pin];
            default:   fire = 1'b0;
        endcase

        base  = SUM_W'(ctrl_q.start[ctrl_q.cur]) + SUM_W'(ctrl_q.rep);
        lap_x = SUM_W'(lap_r);

        if (cfg_wr_i) begin
            // a write wins over any trigger in the same cycle
            ctrl_d.wr_time           = time_i;
            ctrl_d.div[cfg_seg_i]    = cfg_div_i;
            ctrl_d.cyc[cfg_seg_i]    = cfg_cyc_i;
            ctrl_d.mode              = cfg_mode_i;
            ctrl_d.pin               = cfg_pin_i;
            ctrl_d.target            = cfg_target_i;
            ctrl_d.req               = cfg_seg_i;
            if ((cfg_seg_i == ctrl_q.cur) || (cfg_rep_i == REP_FOREVER)) begin
                ctrl_d.cur            = cfg_seg_i;
                ctrl_d.stop           = 1'b0;
                ctrl_d.ext            = (cfg_mode_i == MODE_ALT);
                ctrl_d.ext_sync       = 1'b1;
                ctrl_d.off[cfg_seg_i] = '0;
                ctrl_d.st             = ST_INF;
            end else begin
                ctrl_d.rep      = cfg_rep_i;
                ctrl_d.ext_sync = 1'b0;
                ctrl_d.st       = ST_WAIT;
            end
        end else begin
            ctrl_d.ext_sync = 1'b0;
            unique case (ctrl_q.st)
                ST_WAIT: begin
                    if (fire) begin
                        ctrl_d.stop               = 1'b0;
                        ctrl_d.start[ctrl_q.req]  = lap_r;
                        ctrl_d.cur                = ctrl_q.req;
                        ctrl_d.off[ctrl_q.req]    = (ctrl_q.mode == MODE_LAP) ? '0 : idx_r;
                        ctrl_d.st                 = ST_FIN;
                    end
                end
                ST_FIN: begin
                    if (base + SUM_W'(1) < lap_x) begin
                        ctrl_d.stop = 1'b1;
                    end
                    if ((base < lap_x) && (ctrl_q.off[ctrl_q.cur] <= idx_r)) begin
                        ctrl_d.stop = 1'b1;
                    end
                end
                ST_INF: begin
                    if (ctrl_q.ext_sync) begin
                        ctrl_d.ext_last = ref_lap;
                    end else if (ctrl_q.ext && (lap_r > ctrl_q.ext_last)
                                 && (lap_r[0] != ctrl_q.ext_last[0])) begin
                        ctrl_d.ext_last = lap_r;
                        ctrl_d.cur      = ~ctrl_q.cur;
                    end
                end
                default: ctrl_d.st = ST_WAIT;
            endcase
        end
    end

    assign map_idx = idx_s[ctrl_d.cur];
    assign map_cyc = ctrl_q.cyc[ctrl_d.cur];
    assign map_off = ctrl_d.off[ctrl_d.cur];

    seg_swap_index_map #(.CYC_W(CYC_W)) map_i (
        .idx_i (map_idx),
        .cyc_i (map_cyc),
        .off_i (map_off),
        .stop_i(ctrl_d.stop),
        .idx_o (idx_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            ctrl_q.st  <= ST_WAIT;
            ctrl_q.div <= {DIV_W'(10), DIV_W'(10)};
            ctrl_q.cyc <= {CYC_W'(1), CYC_W'(1)};
            idx_q      <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            idx_q  <= idx_d;
        end
    end

    assign seg_o  = ctrl_q.cur;
    assign stop_o = ctrl_q.stop;
    assign idx_o  = idx_q;

    // ---------------- assertions ----------------
    assert_inf_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && (cfg_rep_i == REP_FOREVER)) |=> ((seg_o == $past(cfg_seg_i)) && !stop_o));

    assert_park_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && (cfg_rep_i != REP_FOREVER) && (cfg_seg_i != seg_o)) |=> $stable(seg_o));

    assert_stop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q.st == ST_FIN) && stop_o && !cfg_wr_i) |=> stop_o);

    assert_fin_seg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q.st == ST_FIN) && !cfg_wr_i) |=> $stable(seg_o));

    assert_idx_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> (idx_o < ((ctrl_q.cyc[ctrl_q.cur] == '0) ? CYC_W'(1) : ctrl_q.cyc[ctrl_q.cur])));

    assert_no_alt_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q.st == ST_INF) && !ctrl_q.ext && !cfg_wr_i) |=> $stable(seg_o));

endmodule

// File: tb/seg_swap_ctrl_tb_top.sv
`timescale 1ns/1ps
module seg_swap_ctrl_tb_top;
    localparam int TIME_W = 20;
    localparam int DIV_W  = 8;
    localparam int CYC_W  = 8;
    localparam int REP_W  = 16;
    localparam int PIN_N  = 4;
    localparam int PIN_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TIME_W-1:0] time_i = '0;
    logic [PIN_N-1:0]  pin_i = '0;
    logic              cfg_wr_i = 1'b0;
    logic              cfg_seg_i = 1'b0;
    logic [REP_W-1:0]  cfg_rep_i = '0;
    logic [DIV_W-1:0]  cfg_div_i = '0;
    logic [CYC_W-1:0]  cfg_cyc_i = '0;
    logic [2:0]        cfg_mode_i = '0;
    logic [PIN_W-1:0]  cfg_pin_i = '0;
    logic [TIME_W-1:0] cfg_target_i = '0;
    logic              seg_o;
    logic [CYC_W-1:0]  idx_o;
    logic              stop_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    seg_swap_ctrl #(
        .TIME_W(TIME_W), .DIV_W(DIV_W), .CYC_W(CYC_W),
        .REP_W(REP_W), .PIN_N(PIN_N), .PIN_W(PIN_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .time_i(time_i), .pin_i(pin_i),
        .cfg_wr_i(cfg_wr_i), .cfg_seg_i(cfg_seg_i), .cfg_rep_i(cfg_rep_i),
        .cfg_div_i(cfg_div_i), .cfg_cyc_i(cfg_cyc_i), .cfg_mode_i(cfg_mode_i),
        .cfg_pin_i(cfg_pin_i), .cfg_target_i(cfg_target_i),
        .seg_o(seg_o), .idx_o(idx_o), .stop_o(stop_o)
    );

    // ---------------- reference model ----------------
    int unsigned m_st;
    bit          m_cur, m_req, m_stop, m_ext;
    int unsigned m_rep, m_mode, m_pin, m_target, m_wrt, m_extlast;
    int unsigned m_div [2];
    int unsigned m_cyc [2];
    int unsigned m_start [2];
    int unsigned m_off [2];
    int unsigned e_idx;
    int unsigned now_t;

    function automatic int unsigned eff(int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function int unsigned t_lap(bit s, int unsigned t);
        return (t / eff(m_div[s])) / eff(m_cyc[s]);
    endfunction

    function int unsigned t_idx(bit s, int unsigned t);
        return (t / eff(m_div[s])) % eff(m_cyc[s]);
    endfunction

    task automatic model_reset();
        m_st = 0; m_cur = 0; m_req = 0; m_stop = 0; m_ext = 0;
        m_rep = 0; m_mode = 0; m_pin = 0; m_target = 0; m_wrt = 0; m_extlast = 0;
        for (int s = 0; s < 2; s++) begin
            m_div[s] = 10; m_cyc[s] = 1; m_start[s] = 0; m_off[s] = 0;
        end
        e_idx = 0;
    endtask

    task automatic model_out(int unsigned t);
        int unsigned c;
        c = eff(m_cyc[m_cur]);
        if (m_stop) e_idx = c - 1;
        else e_idx = (t_idx(m_cur, t) + c - (m_off[m_cur] % c)) % c;
    endtask

    task automatic model_update(int unsigned t, bit [3:0] g);
        int unsigned lr, ir;
        bit fire;
        lr = t_lap(m_req, t);
        ir = t_idx(m_req, t);
        case (m_st)
            0: begin
                fire = (m_mode == 1 && lr > t_lap(m_req, m_wrt)) ||
                       (m_mode == 2 && m_target <= t) ||
                       (m_mode == 3 && g[m_pin]);
                if (fire) begin
                    m_stop = 0;
                    m_start[m_req] = lr;
                    m_cur = m_req;
                    m_off[m_req] = (m_mode == 1) ? 0 : ir;
                    m_st = 1;
                end
            end
            1: begin
                if (longint'(m_start[m_cur]) + m_rep + 1 < lr) m_stop = 1;
                if ((longint'(m_start[m_cur]) + m_rep < lr) && (m_off[m_cur] <= ir)) m_stop = 1;
            end
            default: begin
                if (m_ext && lr > m_extlast && (lr % 2) != (m_extlast % 2)) begin
                    m_extlast = lr;
                    m_cur = !m_cur;
                end
            end
        endcase
        model_out(t);
    endtask

    task automatic model_write(int unsigned t, bit seg, int unsigned rep, int unsigned dv,
                               int unsigned cy, int unsigned mode, int unsigned pin,
                               int unsigned tgt);
        m_div[seg] = dv; m_cyc[seg] = cy;
        m_mode = mode; m_pin = pin; m_target = tgt; m_wrt = t; m_req = seg;
        if (seg == m_cur || rep == 16'hFFFF) begin
            m_cur = seg; m_stop = 0; m_ext = (mode == 4);
            m_off[seg] = 0; m_st = 2;
            m_extlast = t_lap(seg, t);
        end else begin
            m_rep = rep; m_st = 0;
        end
    endtask

    // ---------------- stimulus helpers ----------------
    task automatic check(string tag);
        total++;
        if (seg_o !== m_cur || int'(idx_o) != e_idx || stop_o !== m_stop) begin
            bad++;
            $display("FAIL %s: actual seg=%0d idx=%0d stop=%0d expected seg=%0d idx=%0d stop=%0d",
                     tag, seg_o, idx_o, stop_o, m_cur, e_idx, m_stop);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cfg_wr_i = 0; pin_i = '0; time_i = '0; now_t = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        model_reset();
        repeat (3) @(negedge clk);
    endtask

    task automatic step_time(int unsigned t, string tag);
        @(negedge clk);
        time_i = TIME_W'(t); now_t = t;
        repeat (6) @(negedge clk);
        model_update(t, pin_i);
        check(tag);
    endtask

    task automatic step_pin(bit [3:0] g, string tag);
        @(negedge clk);
        pin_i = g;
        repeat (6) @(negedge clk);
        model_update(now_t, g);
        check(tag);
    endtask

    task automatic write(bit seg, int unsigned rep, int unsigned dv, int unsigned cy,
                         int unsigned mode, int unsigned pin, int unsigned tgt, string tag);
        @(negedge clk);
        cfg_wr_i = 1; cfg_seg_i = seg; cfg_rep_i = REP_W'(rep); cfg_div_i = DIV_W'(dv);
        cfg_cyc_i = CYC_W'(cy); cfg_mode_i = 3'(mode); cfg_pin_i = PIN_W'(pin);
        cfg_target_i = TIME_W'(tgt);
        @(negedge clk);
        cfg_wr_i = 0;
        model_write(now_t, seg, rep, dv, cy, mode, pin, tgt);
        repeat (6) @(negedge clk);
        model_update(now_t, pin_i);
        check(tag);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd2024));
        model_reset();
        do_reset();
        check("R1 reset state");
        step_time(25, "R4 no start after reset");

        // lap sync start, finite stop, re-arm on same segment
        do_reset();
        step_time(5, "R1 time only");
        write(1, 0, 1, 10, 1, 0, 0, "R4 finite write parks");
        step_time(9, "R5 before lap boundary");
        step_time(10, "R5 start on lap boundary");
        step_time(19, "R9 last sample");
        step_time(20, "R8 stop after one lap");
        step_time(35, "R8 frozen while stopped");
        write(1, 3, 1, 10, 1, 0, 0, "R2 same segment resumes");
        step_time(37, "R2 free-running index");

        // time trigger with divider 2, repeat 1
        do_reset();
        step_time(5, "R1 time only");
        write(1, 1, 2, 5, 2, 0, 23, "R4 finite write parks");
        step_time(22, "R6 before target");
        step_time(23, "R6 start at target");
        step_time(40, "R8 below offset no stop");
        step_time(42, "R8 stop at offset");

        // pin trigger
        do_reset();
        step_time(5, "R1 time only");
        write(1, 0, 1, 10, 3, 2, 0, "R4 finite write parks");
        step_time(15, "R7 parked");
        step_pin(4'b0001, "R7 other pin ignored");
        step_pin(4'b0100, "R7 selected pin starts");
        step_time(16, "R9 offset applied");
        step_time(24, "R8 below offset no stop");
        step_time(25, "R8 stop at offset");
        step_pin(4'b0000, "R8 pin low keeps stop");

        // alternation
        do_reset();
        write(0, 16'hFFFF, 1, 10, 4, 0, 0, "R2 same segment endless");
        write(1, 16'hFFFF, 1, 10, 4, 0, 0, "R3 endless switch");
        step_time(5, "R10 no toggle within lap");
        step_time(9, "R10 end of lap");
        step_time(10, "R10 toggle on parity");
        step_time(19, "R10 hold");
        step_time(20, "R10 toggle back");

        // immediate mode never starts; zero divider and cycle
        do_reset();
        write(0, 16'hFFFF, 0, 3, 0, 0, 0, "R9 zero divider");
        step_time(7, "R9 zero divider index");
        write(1, 2, 0, 0, 0, 0, 0, "R4 immediate parks");
        step_time(50, "R4 immediate never starts");
        write(0, 16'hFFFF, 3, 0, 0, 0, 0, "R9 zero cycle");
        step_time(61, "R9 zero cycle index");

        // random mix
        do_reset();
        for (int i = 0; i < 700; i++) begin
            int unsigned r;
            r = $urandom % 10;
            if (r < 2) begin
                int unsigned rep;
                rep = (($urandom % 3) == 0) ? 16'hFFFF : ($urandom % 3);
                write(1'($urandom % 2), rep, $urandom % 5, $urandom % 13, $urandom % 5,
                      $urandom % 4, now_t + ($urandom % 40), "R8 R9 random write");
            end else if (r < 4) begin
                step_pin(4'($urandom), "R7 random pin");
            end else begin
                step_time(now_t + ($urandom % 7), "R9 random time");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule